// File: doc/BRIEF.md
# Erased-Sector Bitflip Checker

When an ECC decode of a flash sector fails, the sector may simply be an erased one that has picked up a few stray zero bits. This block takes the raw sector as a byte stream and makes that call. The stream holds the data bytes, then the spare bytes covered by ECC, then the parity bytes. An erased cell reads as 1, so every 0 bit counts as one flip. The count runs across all three regions. The moment it passes the strength given at start, the block stops taking input and reports an uncorrectable sector.

A sector that ends with no flips is reported clean, and nothing is rewritten. A sector with between one and `strength` flips is reported with its flip count. The block then emits one rewrite byte for every covered byte, and the buffer owner stores these bytes back so the sector reads as fully erased.

The parity region length follows from the strength and the sector size. When that length is not a whole number of bytes, the final parity byte is only partly protected. Only its protected low bits are counted, and only those bits are restored.

Top module: `erased_sector_checker`

## Requirements
- R1: Each accepted byte adds its number of 0 bits to a running count. The count spans data (indices 0..DATA_BYTES-1), then spare (the next FDM_BYTES), then parity, with no reset between regions. On completion `flips` holds the total.
- R2: In the last parity byte, when the parity bit length P is not a multiple of 8, only bit positions 0..(P mod 8)-1 are counted. Zeros in the higher bits have no effect.
- R3: When the count after a byte exceeds `strength`, the next cycle shows `done`=1 and `fail`=1. `flips` then holds the count including that byte. No further input byte is accepted (`in_ready`=0).
- R4: When the full stream is accepted with a count of 0, `done`=1 and `fail`=0 appear the cycle after the last byte, with `flips`=0. No rewrite byte is emitted.
- R5: When the final count is between 1 and `strength`, the block emits one rewrite byte for each index from 0 to the last index, in order, using valid/ready. Each byte is 0xFF, except as stated in R6. `done`=1 with `fail`=0 follows the cycle after the last rewrite byte is accepted.
- R6: The rewrite byte for a partial last parity byte equals the received byte OR'ed with a mask of ones in its low (P mod 8) bits.
- R7: `fail` and `flips` hold their values from `done` until the next `start`. `done` is a one-cycle pulse.
- R8: The parity length is P = strength × (floor(log2(DATA_BYTES×8)) + 1) bits. The block accepts exactly DATA_BYTES + FDM_BYTES + ceil(P/8) bytes, unless it aborts first.
- R9: After reset, `in_ready`, `wr_valid`, `done` and `fail` are 0 and `flips` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a sector check (ignored while busy) |
| strength | input | STR_W (5) | Correctable bit count, latched at start |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Sector byte, in stream order |
| wr_valid | output | 1 | Rewrite byte valid |
| wr_ready | input | 1 | Rewrite byte taken |
| wr_idx | output | IDX_W (7) | Stream index of the rewrite byte |
| wr_data | output | 8 | Rewrite byte value |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sector uncorrectable |
| flips | output | CNT_W (9) | Zero-bit count |

## Verification
A running count that drifts shows up as a wrong `flips` value. It can also show up as an abort on the wrong byte, which the bench sees at once because `in_ready` drops one byte too early or too late. A stale index or last-byte decode changes how many bytes are accepted or rewritten. It also moves the partial-byte mask onto the wrong byte, which corrupts the final rewrite byte or the count from it. These faults appear no later than the completion pulse of the same sector. Stimulus includes garbage in the unprotected high bits of the last parity byte, so a mask fault cannot hide.

// File: rtl/erased_sector_checker.sv
module erased_sector_checker #(
  parameter int DATA_BYTES = 64,
  parameter int FDM_BYTES  = 4,
  parameter int STR_W      = 5,
  localparam int PAR_UNIT   = $clog2(DATA_BYTES * 8 + 1),
  localparam int MAX_PBYTES = (((1 << STR_W) - 1) * PAR_UNIT + 7) / 8,
  localparam int IDX_W      = $clog2(DATA_BYTES + FDM_BYTES + MAX_PBYTES),
  localparam int CNT_W      = STR_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [STR_W-1:0] strength,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] flips
);
  localparam int PBITS_W = STR_W + $clog2(PAR_UNIT + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_WRITE} st_t;

  st_t              st;
  logic [STR_W-1:0] str_q;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [7:0]       keep;

  logic [PBITS_W-1:0] pbits;
  logic [IDX_W-1:0]   last_idx;
  logic [2:0]         tail;
  logic [7:0]         low_mask;
  logic               at_tail;
  logic [CNT_W-1:0]   sum;

  assign pbits    = PBITS_W'(str_q) * PBITS_W'(PAR_UNIT);
  assign last_idx = IDX_W'(DATA_BYTES + FDM_BYTES) + IDX_W'((pbits + PBITS_W'(7)) >> 3) - IDX_W'(1);
  assign tail     = pbits[2:0];
  assign low_mask = 8'((9'd1 << tail) - 9'd1);
  assign at_tail  = (idx == last_idx) && (tail != 3'd0);
  assign sum      = cnt + CNT_W'($countones(~in_data & (at_tail ? low_mask : 8'hFF)));

  assign in_ready = (st == S_RECV);
  assign wr_valid = (st == S_WRITE);
  assign wr_idx   = idx;
  assign wr_data  = at_tail ? (keep | low_mask) : 8'hFF;
  assign flips    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      str_q <= '0;
      cnt   <= '0;
      idx   <= '0;
      keep  <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          str_q <= strength;
          cnt   <= '0;
          idx   <= '0;
          fail  <= 1'b0;
          st    <= S_RECV;
        end
        S_RECV: if (in_valid) begin
          cnt <= sum;
          if (sum > CNT_W'(str_q)) begin
            fail <= 1'b1;
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (idx == last_idx) begin
            keep <= in_data;
            idx  <= '0;
            if (sum == '0) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_WRITE;
            end
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_WRITE: if (wr_ready) begin
          if (idx == last_idx) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_fail_over_strength: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> flips > CNT_W'(str_q));
  a_r5_pass_within_strength: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> flips <= CNT_W'(str_q));
  a_r4_rewrite_needs_flips: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> flips != '0 && !fail);
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !wr_valid && !start |=> $stable(flips) && $stable(fail));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_rewrite_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_idx) && $stable(wr_data));
endmodule

// File: tb/sim_erased_sector_checker.sv
module sim_erased_sector_checker;
  localparam int DB = 64;
  localparam int FB = 4;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, wr_ready = 0;
  logic [4:0] strength = 0;
  logic [7:0] in_data = 0;
  logic in_ready, wr_valid, done, fail;
  logic [6:0] wr_idx;
  logic [7:0] wr_data;
  logic [8:0] flips;

  erased_sector_checker #(.DATA_BYTES(DB), .FDM_BYTES(FB), .STR_W(5)) u0 (
    .clk, .rst_n, .start, .strength, .in_valid, .in_ready, .in_data,
    .wr_valid, .wr_ready, .wr_idx, .wr_data, .done, .fail, .flips);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] sec [0:127];
  logic [7:0] got_d [0:127];
  int got_i [0:127];

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unit_bits();
    int v = DB * 8, l = 0;
    while (v > 1) begin v = v >> 1; l++; end
    return l + 1;
  endfunction

  function automatic int zeros(input logic [7:0] b, input int nbits);
    int z = 0;
    for (int i = 0; i < nbits; i++) if (!b[i]) z++;
    return z;
  endfunction

  task automatic run_case(input int s, input int nflip, input bit garbage_hi);
    int pbits = s * unit_bits();
    int tl = pbits % 8;
    int n = DB + FB + (pbits + 7) / 8;
    int c = 0, e_acc, n_acc = 0, n_wr = 0, cyc = 0;
    bit e_fail = 0, hs_in = 0;
    logic [7:0] e_last;
    for (int i = 0; i < n; i++) sec[i] = 8'hFF;
    for (int k = 0; k < nflip; k++) begin
      int p = $urandom % n;
      int b = (p == n - 1 && tl != 0) ? ($urandom % tl) : ($urandom % 8);
      sec[p][b] = 1'b0;
    end
    if (garbage_hi && tl != 0) sec[n-1] = sec[n-1] & (8'(($urandom % 256)) | 8'((1 << tl) - 1));
    e_acc = n;
    for (int i = 0; i < n; i++) begin
      c += zeros(sec[i], (i == n - 1 && tl != 0) ? tl : 8);
      if (c > s) begin e_fail = 1; e_acc = i + 1; break; end
    end
    e_last = sec[n-1];
    for (int b = 0; b < tl; b++) e_last[b] = 1'b1;

    @(negedge clk); start = 1; strength = 5'(s);
    @(negedge clk); start = 0;
    forever begin
      if (hs_in) n_acc++;
      hs_in = 0;
      if (done || finished) break;
      if (++cyc > 4000) begin chk("R8 watchdog", cyc, 0); break; end
      in_valid = (n_acc < n) && ($urandom % 4 != 0);
      in_data  = sec[n_acc < n ? n_acc : 0];
      wr_ready = ($urandom % 3 != 0);
      hs_in = in_valid && in_ready;
      if (wr_valid && wr_ready && n_wr < 128) begin
        got_i[n_wr] = int'(wr_idx); got_d[n_wr] = wr_data; n_wr++;
      end
      @(negedge clk);
    end
    in_valid = 0; wr_ready = 0;
    chk(e_fail ? "R3 accepted bytes" : "R8 accepted bytes", n_acc, e_acc);
    chk("R3 fail flag", int'(fail), int'(e_fail));
    chk("R1 flip count", int'(flips), c);
    chk((c == 0 || e_fail) ? "R4 rewrite count" : "R5 rewrite count", n_wr, (c == 0 || e_fail) ? 0 : n);
    if (!e_fail && c != 0)
      for (int i = 0; i < n_wr; i++) begin
        chk("R5 rewrite index", got_i[i], i);
        if (i == n - 1 && tl != 0) chk("R6 partial rewrite", int'(got_d[i]), int'(e_last));
        else chk("R5 rewrite 0xFF", int'(got_d[i]), 255);
      end
    repeat (3) @(negedge clk);
    chk("R7 done pulse", int'(done), 0);
    chk("R7 flips held", int'(flips), c);
    chk("R7 fail held", int'(fail), int'(e_fail));
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2;
    chk("R9 in_ready", int'(in_ready), 0);
    chk("R9 wr_valid", int'(wr_valid), 0);
    chk("R9 done", int'(done), 0);
    chk("R9 fail", int'(fail), 0);
    chk("R9 flips", int'(flips), 0);
    #30 rst_n = 1;
    run_case(0, 0, 0);   // R4 clean, no parity
    run_case(0, 1, 0);   // R3 any flip fails at strength 0
    run_case(1, 0, 1);   // R2 garbage above protected bits only
    run_case(1, 1, 1);   // R6 partial byte restore
    run_case(4, 4, 0);   // R5 no partial byte, at limit
    run_case(4, 5, 0);   // R3 one over
    run_case(31, 31, 1); // R8 longest stream
    run_case(7, 0, 0);   // R4
    for (int k = 0; k < 40; k++) begin
      int s = $urandom % 32;
      run_case(s, $urandom % (s + 3), 1'($urandom % 2));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule